// File: doc/BRIEF.md
# Error-Corrected Weight Store

This block holds a small bank of signed 8-bit neural-network weights. Every weight is stored with protection: on write it becomes a 13-bit codeword, built from a 12-bit Hamming code plus one parity bit over the whole word. On every read the codeword is checked and repaired before the weight goes on to a multiply-accumulate stage. A single upset bit anywhere in the word is repaired silently and reported. A pair of upset bits cannot be repaired, so it is reported as uncorrectable and is never passed on as good data.

Two saturating 16-bit counters keep a running tally of repaired reads and uncorrectable reads. A synchronous clear input zeroes both counters. A test port flips chosen stored bits in place: it XORs a 13-bit mask into the codeword at a given address. This lets a bench or a lab setup inject upsets without going through the write path.

Top module: `ecc_weight_store`

## Requirements
- R1: A written byte is stored as a codeword. A later read of that address, with no upset, returns the same byte with both status flags low.
- R2: A read takes one cycle. `rd_valid` is high in exactly the cycle after `rd_en` was sampled high. `rd_corrected` and `rd_uncorrectable` are only ever high together with `rd_valid`, never both at once, and are valid in the same cycle as `rd_data`. When no read is made, `rd_data` holds its last value.
- R3: Codeword bit i corresponds to Hamming position i+1 for i = 0..11. Check bits sit at mask bits 0, 1, 3 and 7. Data bits 0..7 sit at mask bits 2, 4, 5, 6, 8, 9, 10 and 11, in that order. Mask bit 12 is the overall parity bit. A read of a word with any one of the 13 bits flipped returns the original byte with `rd_corrected` high.
- R4: A read of a word with any two bits flipped raises `rd_uncorrectable` and keeps `rd_corrected` low.
- R5: A flip of the overall parity bit alone (mask bit 12) counts as a single error. It is repaired and raises `rd_corrected`.
- R6: `sec_count` rises by one for each read that raises `rd_corrected`. It becomes visible in the same cycle as the flag and holds at 16'hFFFF once there.
- R7: `ded_count` rises by one for each read that raises `rd_uncorrectable`, with the same timing, and also saturates at 16'hFFFF.
- R8: `cnt_clr` zeroes both counters at the next edge. It takes priority over an increment in the same cycle.
- R9: A fault injection XORs `inj_mask` into the stored codeword at `inj_addr`. The change persists, so injecting the same mask again restores the word. If a write targets the same address in the same cycle, the write wins and the injection is dropped.
- R10: A write re-encodes the word, which clears any upset stored at that address.
- R11: Reset clears the outputs and both counters. Every address then reads as byte 0 with no error flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Weight byte to store |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Repaired weight byte |
| rd_valid | output | 1 | Read result present |
| rd_corrected | output | 1 | Single error repaired on this read |
| rd_uncorrectable | output | 1 | Double error detected on this read |
| inj_en | input | 1 | Fault-injection strobe |
| inj_addr | input | ADDR_W | Fault-injection address |
| inj_mask | input | 13 | Bits to flip in the stored codeword |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| sec_count | output | 16 | Saturating count of repaired reads |
| ded_count | output | 16 | Saturating count of uncorrectable reads |

## Verification
The assertions assume that `cnt_clr` and `rd_en` are driven to known values from reset onward. They also assume that a stored word never builds up more than two flipped bits, because three or more flips can alias to a single-error syndrome and would defeat the flag checks. The stimulus keeps within this. Every injection it makes is either undone by the same mask or overwritten by a write before a new one lands. Its reference model tracks the accumulated flip mask for each address and only ever sees weights 0, 1 or 2.

// File: rtl/wstore_pkg.sv
package wstore_pkg;

    localparam int DATA_W = 8;
    localparam int HAM_W  = 12;
    localparam int CODE_W = HAM_W + 1;
    localparam int SYN_W  = 4;

    // Positions 1..HAM_W map to code bits 0..HAM_W-1; powers of two hold checks.
    function automatic logic [CODE_W-1:0] secded_encode(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] cw;
        logic              par;
        int                di;
        cw = '0;
        di = 0;
        for (int pos = 1; pos <= HAM_W; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                cw[pos-1] = d[di];
                di++;
            end
        end
        for (int k = 0; k < SYN_W; k++) begin
            par = 1'b0;
            for (int pos = 1; pos <= HAM_W; pos++) begin
                if (((pos >> k) & 1) == 1) par ^= cw[pos-1];
            end
            cw[(1 << k) - 1] = par;
        end
        cw[CODE_W-1] = ^cw[HAM_W-1:0];
        return cw;
    endfunction

    function automatic logic [DATA_W-1:0] secded_extract(input logic [CODE_W-1:0] cw);
        logic [DATA_W-1:0] d;
        int                di;
        d  = '0;
        di = 0;
        for (int pos = 1; pos <= HAM_W; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                d[di] = cw[pos-1];
                di++;
            end
        end
        return d;
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              corr;
        logic              unc;
    } rd_state_t;

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import wstore_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    output logic [CODE_W-1:0] code_out
);
    always_comb begin
        code_out = secded_encode(data_in);
    end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import wstore_pkg::*;
(
    input  logic [CODE_W-1:0] code_in,
    output logic [DATA_W-1:0] data_out,
    output logic              single_err,
    output logic              double_err
);
    logic [SYN_W-1:0]  syn;
    logic              par_bad;
    logic [CODE_W-1:0] flip;

    always_comb begin
        syn = '0;
        for (int i = 0; i < HAM_W; i++) begin
            if (code_in[i]) syn ^= SYN_W'(i + 1);
        end
        par_bad    = ^code_in;
        flip       = '0;
        single_err = 1'b0;
        double_err = 1'b0;
        if (par_bad) begin
            if (syn == '0) begin
                flip[CODE_W-1] = 1'b1;
                single_err     = 1'b1;
            end else if (int'(syn) <= HAM_W) begin
                for (int i = 0; i < HAM_W; i++) begin
                    if (syn == SYN_W'(i + 1)) flip[i] = 1'b1;
                end
                single_err = 1'b1;
            end else begin
                double_err = 1'b1;
            end
        end else if (syn != '0) begin
            double_err = 1'b1;
        end
        data_out = secded_extract(code_in ^ flip);
    end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                       cnt_d = '0;
        else if (inc && cnt_q != TOP)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/ecc_weight_store.sv
module ecc_weight_store
    import wstore_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int CNT_W  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              rd_corrected,
    output logic              rd_uncorrectable,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [12:0]       inj_mask,
    input  logic              cnt_clr,
    output logic [CNT_W-1:0]  sec_count,
    output logic [CNT_W-1:0]  ded_count
);
    logic [CODE_W-1:0] mem_d [DEPTH];
    logic [CODE_W-1:0] mem_q [DEPTH];
    logic [CODE_W-1:0] wr_code;
    logic [CODE_W-1:0] rd_code;
    logic [DATA_W-1:0] dec_data;
    logic              dec_single, dec_double;
    rd_state_t         rs_d, rs_q;

    secded_enc u_enc (
        .data_in  (wr_data),
        .code_out (wr_code)
    );

    assign rd_code = mem_q[rd_addr];

    secded_dec u_dec (
        .code_in    (rd_code),
        .data_out   (dec_data),
        .single_err (dec_single),
        .double_err (dec_double)
    );

    // Per-word next value: a write overrides an injection at the same address.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en && wr_addr == ADDR_W'(g))
                mem_d[g] = wr_code;
            else if (inj_en && inj_addr == ADDR_W'(g))
                mem_d[g] = mem_q[g] ^ inj_mask;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    always_comb begin
        rs_d       = rs_q;
        rs_d.valid = rd_en;
        rs_d.corr  = rd_en & dec_single;
        rs_d.unc   = rd_en & dec_double;
        if (rd_en) rs_d.data = dec_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    sat_counter #(.W(CNT_W)) u_sec_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (rd_en & dec_single),
        .count (sec_count)
    );

    sat_counter #(.W(CNT_W)) u_ded_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (rd_en & dec_double),
        .count (ded_count)
    );

    assign rd_data          = rs_q.data;
    assign rd_valid         = rs_q.valid;
    assign rd_corrected     = rs_q.corr;
    assign rd_uncorrectable = rs_q.unc;

endmodule

// File: rtl/wstore_chk.sv
module wstore_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             cnt_clr,
    input logic             rd_valid,
    input logic             rd_corrected,
    input logic             rd_uncorrectable,
    input logic [CNT_W-1:0] sec_count,
    input logic [CNT_W-1:0] ded_count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);                                                  // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);                                                // R2
    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_corrected || rd_uncorrectable) |-> rd_valid);                     // R2
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_corrected && rd_uncorrectable));                                 // R4
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_corrected && !$past(cnt_clr) && $past(sec_count) != TOP)
            |-> sec_count == $past(sec_count) + 1'b1);                        // R6
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_corrected && !$past(cnt_clr)) |-> $stable(sec_count));           // R6
    AST_DED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_uncorrectable && !$past(cnt_clr) && $past(ded_count) != TOP)
            |-> ded_count == $past(ded_count) + 1'b1);                        // R7
    AST_DED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_uncorrectable && !$past(cnt_clr)) |-> $stable(ded_count));       // R7
    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sec_count) == TOP && !$past(cnt_clr)) |-> sec_count == TOP);   // R6
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (sec_count == '0 && ded_count == '0));                    // R8
endmodule

bind ecc_weight_store wstore_chk #(.CNT_W(CNT_W)) u_wstore_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .rd_en            (rd_en),
    .cnt_clr          (cnt_clr),
    .rd_valid         (rd_valid),
    .rd_corrected     (rd_corrected),
    .rd_uncorrectable (rd_uncorrectable),
    .sec_count        (sec_count),
    .ded_count        (ded_count)
);

// File: tb/test_ecc_weight_store.sv
module test_ecc_weight_store;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, inj_en = 1'b0, cnt_clr = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0, inj_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [12:0]   inj_mask = '0;
    logic [7:0]    rd_data;
    logic          rd_valid, rd_corrected, rd_uncorrectable;
    logic [15:0]   sec_count, ded_count;

    ecc_weight_store i_ecc_weight_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_corrected(rd_corrected),
        .rd_uncorrectable(rd_uncorrectable),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask),
        .cnt_clr(cnt_clr), .sec_count(sec_count), .ded_count(ded_count)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int fails  = 0;

    // Behavioural reference: stored byte plus accumulated flip mask per address.
    logic [7:0]  m_data [DEPTH];
    logic [12:0] m_mask [DEPTH];
    logic [7:0]  e_data  = '0;
    logic        e_known = 1'b1;
    logic        e_valid = 1'b0, e_corr = 1'b0, e_unc = 1'b0;
    int          e_sec = 0, e_ded = 0;

    initial for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_mask[i] = '0; end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_mask[i] = '0; end
            e_data = '0; e_known = 1'b1; e_valid = 0; e_corr = 0; e_unc = 0;
            e_sec = 0; e_ded = 0;
        end else begin
            int w;
            w = $countones(m_mask[rd_addr]);
            e_valid = rd_en;
            e_corr  = rd_en && (w == 1);
            e_unc   = rd_en && (w == 2);
            if (rd_en) begin
                e_known = (w <= 1);
                e_data  = m_data[rd_addr];
            end
            if (cnt_clr) begin
                e_sec = 0; e_ded = 0;
            end else begin
                if (e_corr && e_sec < 65535) e_sec++;
                if (e_unc  && e_ded < 65535) e_ded++;
            end
            if (wr_en) begin
                m_data[wr_addr] = wr_data;
                m_mask[wr_addr] = '0;
            end
            if (inj_en && !(wr_en && wr_addr == inj_addr))
                m_mask[inj_addr] = m_mask[inj_addr] ^ inj_mask;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        chk(rd_valid == e_valid, "R2 rd_valid", int'(rd_valid), int'(e_valid));
        chk(rd_corrected == e_corr, "R3 rd_corrected", int'(rd_corrected), int'(e_corr));
        chk(rd_uncorrectable == e_unc, "R4 rd_uncorrectable", int'(rd_uncorrectable), int'(e_unc));
        chk(int'(sec_count) == e_sec, "R6 sec_count", int'(sec_count), e_sec);
        chk(int'(ded_count) == e_ded, "R7 ded_count", int'(ded_count), e_ded);
        if (e_known)
            chk(rd_data == e_data, "R1 rd_data", int'(rd_data), int'(e_data));
    end

    task automatic do_write(input int a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic do_inject(input int a, input logic [12:0] m);
        @(negedge clk); inj_en = 1; inj_addr = AW'(a); inj_mask = m;
        @(negedge clk); inj_en = 0;
    endtask

    task automatic do_read(input int a);
        @(negedge clk); rd_en = 1; rd_addr = AW'(a);
        @(negedge clk); rd_en = 0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(rd_valid == 0 && rd_data == 0 && sec_count == 0 && ded_count == 0,
            "R11 reset outputs", int'(rd_data), 0);
        rst_n = 1;
        do_read(5);
        chk(rd_data == 8'h00 && !rd_corrected && !rd_uncorrectable, "R11 post-reset read",
            int'(rd_data), 0);

        // R1: write and read back every address
        for (int i = 0; i < DEPTH; i++) do_write(i, pat(i));
        for (int i = 0; i < DEPTH; i++) begin
            do_read(i);
            chk(rd_data == pat(i) && !rd_corrected, "R1 clean readback", int'(rd_data), int'(pat(i)));
        end

        // R2: latency, valid for exactly one cycle
        @(negedge clk); rd_en = 1; rd_addr = 4'd2;
        @(negedge clk); rd_en = 0;
        chk(rd_valid == 1, "R2 valid one cycle after", int'(rd_valid), 1);
        @(negedge clk);
        chk(rd_valid == 0 && rd_data == pat(2), "R2 valid drops, data holds", int'(rd_data), int'(pat(2)));

        // R3 / R5: every single-bit flip is repaired
        for (int b = 0; b < 13; b++) begin
            do_inject(3, 13'(1 << b));
            do_read(3);
            chk(rd_data == pat(3) && rd_corrected, b == 12 ? "R5 parity-bit flip" : "R3 single flip",
                int'(rd_data), int'(pat(3)));
            do_inject(3, 13'(1 << b));
        end

        // R4: double flips flagged
        for (int b = 0; b < 12; b++) begin
            logic [12:0] m;
            m = 13'(1 << b) | 13'(1 << (12 - b / 3));
            if (m[b] && $countones(m) == 2) begin
                do_inject(4, m);
                do_read(4);
                chk(rd_uncorrectable && !rd_corrected, "R4 double flip", int'(rd_uncorrectable), 1);
                do_inject(4, m);
            end
        end

        // R9: write wins over same-cycle injection; injection persists
        @(negedge clk); wr_en = 1; wr_addr = 4'd6; wr_data = 8'h81;
        inj_en = 1; inj_addr = 4'd6; inj_mask = 13'h0005;
        @(negedge clk); wr_en = 0; inj_en = 0;
        do_read(6);
        chk(rd_data == 8'h81 && !rd_corrected && !rd_uncorrectable, "R9 write wins",
            int'(rd_data), 8'h81);
        do_inject(6, 13'h0100);
        do_read(6);
        do_read(6);
        chk(rd_corrected && rd_data == 8'h81, "R9 injection persists", int'(rd_corrected), 1);
        do_inject(6, 13'h0100);
        do_read(6);
        chk(!rd_corrected, "R9 reinjection restores", int'(rd_corrected), 0);

        // R10: write scrubs an upset
        do_inject(7, 13'h0840);
        do_write(7, 8'hF0);
        do_read(7);
        chk(rd_data == 8'hF0 && !rd_uncorrectable && !rd_corrected, "R10 write clears upset",
            int'(rd_data), 8'hF0);

        // R8: clear beats simultaneous increment
        do_inject(1, 13'h0010);
        @(negedge clk); rd_en = 1; rd_addr = 4'd1; cnt_clr = 1;
        @(negedge clk); rd_en = 0; cnt_clr = 0;
        chk(sec_count == 0 && ded_count == 0 && rd_corrected, "R8 clear priority",
            int'(sec_count), 0);

        // R6 / R7: saturation, alternating single and double upsets
        do_inject(2, 13'h0003);
        @(negedge clk); rd_en = 1;
        for (int k = 0; k < 2 * 65537; k++) begin
            rd_addr = (k % 2 == 0) ? 4'd1 : 4'd2;
            @(negedge clk);
        end
        rd_en = 0;
        @(negedge clk);
        chk(sec_count == 16'hFFFF, "R6 sec saturates", int'(sec_count), 16'hFFFF);
        chk(ded_count == 16'hFFFF, "R7 ded saturates", int'(ded_count), 16'hFFFF);
        @(negedge clk); cnt_clr = 1;
        @(negedge clk); cnt_clr = 0;
        chk(sec_count == 0 && ded_count == 0, "R8 clear after saturation", int'(sec_count), 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule